// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Dual Alarm

This block keeps a free-running seconds-style count for a chip that spends most of its life asleep. A slow timebase clock (nominally 32.768 kHz) arrives on its own pin. The block brings its rising edges into the bus clock domain through a synchronizer and feeds them to a programmable prescaler. The prescaler emits one tick every 2 x (DIV+1) timebase edges, so a divider value of 1023 gives 16 ticks per second from a 32.768 kHz source. Each tick advances a 32-bit counter and raises a periodic event.

Two compare registers watch the counter. When a tick carries the counter onto a compare value, the matching alarm event is latched. An enabled alarm event drives both the interrupt line and a wake-up line for the power controller. Software reaches everything through a small word-addressed register port: the counter, the divider, both compare values, a status word that mixes write-one-to-clear events with plain enable bits, a clock-select field that must hold 3 for counting to run, and a scratch word that keeps whatever is written to it.

All state lives in the bus clock domain. A read of the counter therefore always returns a coherent value, with no retry loop in software.

Top module: `rtc_lp_counter`

## Requirements
- R1: After reset the counter, divider, both compare values, clock select, scratch word, all event flags and all enables read as 0, and `irq_o` and `wake_o` are low.
- R2: A rising edge on `rtc_clk_i` is counted only when the clock-select field (offset 0x1C, bits 1:0, read back as written) equals 3. Any other value freezes both the prescaler and the counter. A counted edge reaches the prescaler at the third `clk` rising edge after it appears on the pin.
- R3: The prescaler produces one tick every 2 x (DIV+1) counted edges, where DIV is the 16-bit divider at offset 0x0C. Writing the divider restarts the prescaler from zero.
- R4: Each tick adds one to the 32-bit counter at offset 0x00, which wraps from 0xFFFFFFFF to 0. The wrap sets no event of its own.
- R5: A bus write to the counter loads the written value. It takes priority over a tick in the same cycle, and that tick then raises no alarm event.
- R6: Every tick sets the periodic event flag (status bit 1), whose interrupt enable is status bit 3.
- R7: Compare register A (offset 0x04) latches event bit 0 (enable bit 2), and compare register B (offset 0x18) latches event bit 4 (enable bit 6), when a tick moves the counter onto the compare value.
- R8: Writing 1 to an event bit (0, 1 or 4) of the status word (offset 0x08) clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as its clear stays set. Enable bits 2, 3 and 6 are plain read/write bits, and all other status bits read 0.
- R9: `irq_o` is high exactly when some event flag and its own enable are both set. `wake_o` is high exactly when an alarm flag and its own enable are both set.
- R10: The scratch word at offset 0x40 keeps the last value written. Unmapped offsets read 0. Read data appears on `rdata_o` one cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_clk_i | input | 1 | Slow timebase clock, asynchronous to `clk` |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined enabled-event interrupt |
| wake_o | output | 1 | Enabled alarm wake-up request |

## Verification
On every cycle, the bound checker enforces several invariants. Ticks stay gated off when the clock select is not 3. The counter moves by exactly one per tick, holds otherwise, and loads the written value on a counter write. The prescaler never passes the divider. A tick always leaves the periodic event set, and a one-write clears it when no tick competes. Wake-up never appears without the interrupt. Only the bench scenarios can show the end-to-end behaviour: the actual tick rate for a given divider, the restart after a divider change, alarm matches landing on the right count, the wrap back to zero, the masking of an event by its enable, and retention of the scratch word. The bench runs a behavioural reference model beside the design and compares the read data and both outputs on every clock.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;

   localparam int unsigned DATA_W     = 32;
   localparam int unsigned NUM_ALM    = 2;
   localparam int unsigned CLKSEL_W   = 2;
   localparam int unsigned CLKSEL_RTC = 3;

   localparam int unsigned OFF_CNT    = 'h00;
   localparam int unsigned OFF_STAT   = 'h08;
   localparam int unsigned OFF_DIV    = 'h0C;
   localparam int unsigned OFF_CSEL   = 'h1C;
   localparam int unsigned OFF_SCR    = 'h40;

   localparam int unsigned HZ_FLAG_BIT = 1;
   localparam int unsigned HZ_EN_BIT   = 3;

   // compare register offsets, indexed by alarm number
   function automatic int unsigned alm_off(int unsigned idx);
      return (idx == 0) ? 'h04 : 'h18;
   endfunction

   function automatic int unsigned alm_flag_bit(int unsigned idx);
      return (idx == 0) ? 0 : 4;
   endfunction

   function automatic int unsigned alm_en_bit(int unsigned idx);
      return (idx == 0) ? 2 : 6;
   endfunction

endpackage

// File: rtl/rtc_lp_edge_sync.sv
module rtc_lp_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   localparam int unsigned LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_lp_edge_sync: STAGES must be at least 2");
   end

   // sh[0..STAGES-1] is the synchronizer chain, sh[STAGES] holds the previous sample
   logic [LAST:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else begin
         sh <= {sh[LAST-1:0], async_i};
      end
   end

   assign rise_o = sh[LAST-1] & ~sh[LAST];

endmodule

// File: rtl/rtc_lp_prescaler.sv
module rtc_lp_prescaler #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o,
   output logic [DIV_W-1:0] presc_o
);

   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_div
      $error("rtc_lp_prescaler: DIV_W out of range");
   end

   logic [DIV_W-1:0] presc_q;
   logic             half_q;
   logic             term;

   assign term = (presc_q == div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         half_q  <= 1'b0;
      end else if (restart_i) begin
         presc_q <= '0;
         half_q  <= 1'b0;
      end else if (step_i) begin
         if (term) begin
            presc_q <= '0;
            half_q  <= ~half_q;
         end else begin
            presc_q <= presc_q + 1'b1;
         end
      end
   end

   // a full period is two half periods of DIV+1 steps each
   assign tick_o  = step_i & ~restart_i & term & half_q;
   assign presc_o = presc_q;

endmodule

// File: rtl/rtc_lp_alarm.sv
module rtc_lp_alarm #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] next_cnt_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_wdata_i,
   input  logic             clr_i,
   output logic             flag_o,
   output logic [CNT_W-1:0] cmp_o
);

   logic [CNT_W-1:0] cmp_q;
   logic             flag_q;
   logic             hit;

   // a match counts only when the counter really advances onto the value
   assign hit = tick_i & ~cnt_wr_i & (next_cnt_i == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (cmp_wr_i) begin
            cmp_q <= cmp_wdata_i;
         end
         flag_q <= (flag_q & ~clr_i) | hit;
      end
   end

   assign flag_o = flag_q;
   assign cmp_o  = cmp_q;

endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter
   import rtc_lp_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtc_clk_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              wake_o
);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("rtc_lp_counter: CNT_W must fit the data bus");
   end
   if (DIV_W > DATA_W) begin : g_bad_divw
      $error("rtc_lp_counter: DIV_W must fit the data bus");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("rtc_lp_counter: ADDR_W too narrow for the register map");
   end

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFF_CNT);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);
   localparam logic [ADDR_W-1:0] A_CSEL = ADDR_W'(OFF_CSEL);
   localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFF_SCR);

   // bus decode
   logic wr, rd;
   logic cnt_wr, st_wr, div_wr, csel_wr, scr_wr;

   assign wr      = req_i & we_i;
   assign rd      = req_i & ~we_i;
   assign cnt_wr  = wr & (addr_i == A_CNT);
   assign st_wr   = wr & (addr_i == A_STAT);
   assign div_wr  = wr & (addr_i == A_DIV);
   assign csel_wr = wr & (addr_i == A_CSEL);
   assign scr_wr  = wr & (addr_i == A_SCR);

   // configuration registers
   logic [DIV_W-1:0]    div_q;
   logic [CLKSEL_W-1:0] clksel_q;
   logic [DATA_W-1:0]   scratch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         clksel_q  <= '0;
         scratch_q <= '0;
      end else begin
         if (div_wr)  div_q     <= wdata_i[DIV_W-1:0];
         if (csel_wr) clksel_q  <= wdata_i[CLKSEL_W-1:0];
         if (scr_wr)  scratch_q <= wdata_i;
      end
   end

   // timebase path
   logic rtc_rise;
   logic step;
   logic tick;
   logic [DIV_W-1:0] presc;

   rtc_lp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (rtc_clk_i),
      .rise_o  (rtc_rise)
   );

   assign step = rtc_rise & (clksel_q == CLKSEL_W'(CLKSEL_RTC));

   rtc_lp_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .restart_i (div_wr),
      .div_i     (div_q),
      .tick_o    (tick),
      .presc_o   (presc)
   );

   // main counter
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= wdata_i[CNT_W-1:0];
      end else if (tick) begin
         cnt_q <= cnt_inc;
      end
   end

   // periodic event and enables
   logic               hz_flag;
   logic               hz_en;
   logic [NUM_ALM-1:0] al_en;
   logic [NUM_ALM-1:0] al_flag;
   logic [CNT_W-1:0]   al_cmp [NUM_ALM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hz_flag <= 1'b0;
         hz_en   <= 1'b0;
         al_en   <= '0;
      end else begin
         hz_flag <= (hz_flag & ~(st_wr & wdata_i[HZ_FLAG_BIT])) | tick;
         if (st_wr) begin
            hz_en <= wdata_i[HZ_EN_BIT];
            for (int i = 0; i < NUM_ALM; i++) begin
               al_en[i] <= wdata_i[alm_en_bit(i)];
            end
         end
      end
   end

   // compare units
   for (genvar gi = 0; gi < NUM_ALM; gi++) begin : g_alm
      localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(alm_off(gi));
      localparam int unsigned       FBIT  = alm_flag_bit(gi);

      rtc_lp_alarm #(.CNT_W(CNT_W)) u_alm (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick_i      (tick),
         .cnt_wr_i    (cnt_wr),
         .next_cnt_i  (cnt_inc),
         .cmp_wr_i    (wr & (addr_i == A_CMP)),
         .cmp_wdata_i (wdata_i[CNT_W-1:0]),
         .clr_i       (st_wr & wdata_i[FBIT]),
         .flag_o      (al_flag[gi]),
         .cmp_o       (al_cmp[gi])
      );
   end

   // outputs
   assign wake_o = |(al_flag & al_en);
   assign irq_o  = wake_o | (hz_flag & hz_en);

   // read path
   logic [DATA_W-1:0] st_word;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      st_word              = '0;
      st_word[HZ_FLAG_BIT] = hz_flag;
      st_word[HZ_EN_BIT]   = hz_en;
      for (int i = 0; i < NUM_ALM; i++) begin
         st_word[alm_flag_bit(i)] = al_flag[i];
         st_word[alm_en_bit(i)]   = al_en[i];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (addr_i == A_CNT) begin
         rd_mux[CNT_W-1:0] = cnt_q;
      end else if (addr_i == A_STAT) begin
         rd_mux = st_word;
      end else if (addr_i == A_DIV) begin
         rd_mux[DIV_W-1:0] = div_q;
      end else if (addr_i == A_CSEL) begin
         rd_mux[CLKSEL_W-1:0] = clksel_q;
      end else if (addr_i == A_SCR) begin
         rd_mux = scratch_q;
      end else begin
         for (int i = 0; i < NUM_ALM; i++) begin
            if (addr_i == ADDR_W'(alm_off(i))) begin
               rd_mux[CNT_W-1:0] = al_cmp[i];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (rd) begin
         rdata_o <= rd_mux;
      end
   end

endmodule

// File: rtl/rtc_lp_counter_chk.sv
module rtc_lp_counter_chk #(
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned CLKSEL_W = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic                cnt_wr,
   input logic                st_wr,
   input logic [CNT_W-1:0]    cnt_q,
   input logic [DIV_W-1:0]    presc,
   input logic [DIV_W-1:0]    div_q,
   input logic [CLKSEL_W-1:0] clksel_q,
   input logic                hz_flag,
   input logic [31:0]         wdata_i,
   input logic                irq_o,
   input logic                wake_o
);

   p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clksel_q != CLKSEL_W'(3)) |-> !tick);

   p_presc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      presc <= div_q);

   p_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));

   p_hz_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> hz_flag);

   p_hz_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wdata_i[1] && !tick) |=> !hz_flag);

   p_wake_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> irq_o);

endmodule

bind rtc_lp_counter rtc_lp_counter_chk #(
   .CNT_W    (CNT_W),
   .DIV_W    (DIV_W),
   .CLKSEL_W (rtc_lp_pkg::CLKSEL_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .cnt_wr   (cnt_wr),
   .st_wr    (st_wr),
   .cnt_q    (cnt_q),
   .presc    (presc),
   .div_q    (div_q),
   .clksel_q (clksel_q),
   .hz_flag  (hz_flag),
   .wdata_i  (wdata_i),
   .irq_o    (irq_o),
   .wake_o   (wake_o)
);

// File: tb/rtc_lp_counter_tb_top.sv
`timescale 1ns/1ps
module rtc_lp_counter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rtc_clk = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic        wake;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   // slow timebase: one period every 6 bus clocks
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         rtc_clk = ~rtc_clk;
      end
   end

   rtc_lp_counter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rtc_clk_i (rtc_clk),
      .req_i     (req),
      .we_i      (we),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .irq_o     (irq),
      .wake_o    (wake)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_cnt, m_scr, m_rd;
   logic [31:0] m_cmp [2];
   logic [15:0] m_div;
   logic [1:0]  m_csel;
   int          m_presc;
   bit          m_half, m_hzf, m_hze;
   bit          m_alf [2];
   bit          m_ale [2];
   bit          pin_hist [3];

   function automatic logic [31:0] m_read(input logic [7:0] a);
      logic [31:0] v;
      v = '0;
      case (a)
         8'h00: v = m_cnt;
         8'h04: v = m_cmp[0];
         8'h08: v = {25'd0, m_ale[1], 1'b0, m_alf[1], m_hze, m_ale[0], m_hzf, m_alf[0]};
         8'h0C: v = {16'd0, m_div};
         8'h18: v = m_cmp[1];
         8'h1C: v = {30'd0, m_csel};
         8'h40: v = m_scr;
         default: v = '0;
      endcase
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_scr = '0; m_rd = '0; m_div = '0; m_csel = '0;
         m_presc = 0; m_half = 0; m_hzf = 0; m_hze = 0;
         for (int i = 0; i < 2; i++) begin
            m_cmp[i] = '0; m_alf[i] = 0; m_ale[i] = 0;
         end
         for (int i = 0; i < 3; i++) pin_hist[i] = 0;
      end else begin
         bit seen, tk, cw, sw;
         logic [31:0] nxt;
         bit hit [2];
         // a pin rise two samples back reaches the prescaler now
         seen = pin_hist[1] && !pin_hist[2];
         pin_hist[2] = pin_hist[1];
         pin_hist[1] = pin_hist[0];
         pin_hist[0] = rtc_clk;
         if (req && !we) m_rd = m_read(addr);
         tk = 0;
         if (req && we && addr == 8'h0C) begin
            m_presc = 0; m_half = 0;
         end else if (seen && m_csel == 2'd3) begin
            if (m_presc == int'(m_div)) begin
               m_presc = 0;
               tk = m_half;
               m_half = !m_half;
            end else begin
               m_presc++;
            end
         end
         cw = req && we && addr == 8'h00;
         sw = req && we && addr == 8'h08;
         nxt = m_cnt + 32'd1;
         for (int i = 0; i < 2; i++) hit[i] = tk && !cw && (nxt == m_cmp[i]);
         m_hzf = (m_hzf && !(sw && wdata[1])) || tk;
         m_alf[0] = (m_alf[0] && !(sw && wdata[0])) || hit[0];
         m_alf[1] = (m_alf[1] && !(sw && wdata[4])) || hit[1];
         if (sw) begin
            m_ale[0] = wdata[2]; m_hze = wdata[3]; m_ale[1] = wdata[6];
         end
         if (cw) m_cnt = wdata;
         else if (tk) m_cnt = nxt;
         if (req && we) begin
            case (addr)
               8'h04: m_cmp[0] = wdata;
               8'h18: m_cmp[1] = wdata;
               8'h0C: m_div = wdata[15:0];
               8'h1C: m_csel = wdata[1:0];
               8'h40: m_scr = wdata;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ew, ei;
         ew = (m_alf[0] && m_ale[0]) || (m_alf[1] && m_ale[1]);
         ei = ew || (m_hzf && m_hze);
         check(rdata == m_rd, "R10 model rdata", rdata, m_rd);
         check(irq == ei, "R9 model irq", {31'd0, irq}, {31'd0, ei});
         check(wake == ew, "R9 model wake", {31'd0, wake}, {31'd0, ew});
      end
   end

   // ---------------- bus tasks (called at a falling edge) ----------------
   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      req = 1; we = 1; addr = a; wdata = d;
      @(negedge clk);
      req = 0; we = 0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      req = 1; we = 0; addr = a;
      @(negedge clk);
      req = 0;
      d = rdata;
   endtask

   task automatic wait_status_bit(input int b);
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < 4000 && !v[b]; k++) bus_rd(8'h08, v);
   endtask

   // ---------------- directed scenarios ----------------
   initial begin
      logic [31:0] v, v2;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      bus_rd(8'h00, v); check(v == 0, "R1 counter reset", v, 0);
      bus_rd(8'h08, v); check(v == 0, "R1 status reset", v, 0);
      bus_rd(8'h0C, v); check(v == 0, "R1 divider reset", v, 0);
      bus_rd(8'h04, v); check(v == 0, "R1 compare A reset", v, 0);
      bus_rd(8'h40, v); check(v == 0, "R1 scratch reset", v, 0);
      check(!irq && !wake, "R1 outputs low", {30'd0, irq, wake}, 0);

      // R2 clock select not 3: nothing counts
      bus_wr(8'h0C, 32'd1);
      repeat (200) @(negedge clk);
      bus_rd(8'h00, v); check(v == 0, "R2 frozen with select 0", v, 0);
      bus_wr(8'h1C, 32'd2);
      repeat (200) @(negedge clk);
      bus_rd(8'h00, v); check(v == 0, "R2 frozen with select 2", v, 0);
      bus_wr(8'h1C, 32'h7);
      bus_rd(8'h1C, v); check(v == 3, "R2 select field readback", v, 3);

      // R3/R4 rate with DIV=1: one tick per 24 bus clocks
      bus_wr(8'h0C, 32'd1);
      bus_wr(8'h00, 32'd0);
      repeat (240) @(negedge clk);
      bus_rd(8'h00, v); check(v >= 9 && v <= 11, "R3 ticks at DIV=1", v, 10);
      bus_wr(8'h0C, 32'd3);
      bus_rd(8'h0C, v); check(v == 3, "R3 divider readback", v, 3);
      bus_wr(8'h00, 32'd0);
      repeat (480) @(negedge clk);
      bus_rd(8'h00, v); check(v >= 9 && v <= 11, "R3 ticks at DIV=3", v, 10);
      bus_wr(8'h0C, 32'd1);

      // R5 counter load
      bus_wr(8'h1C, 32'd0);
      bus_wr(8'h00, 32'h1234_5678);
      bus_rd(8'h00, v); check(v == 32'h1234_5678, "R5 counter load", v, 32'h1234_5678);

      // R6/R9 periodic event masked, then unmasked
      bus_wr(8'h08, 32'h13);
      bus_wr(8'h1C, 32'd3);
      wait_status_bit(1);
      check(!irq, "R9 masked periodic event", {31'd0, irq}, 0);
      bus_wr(8'h1C, 32'd0);
      bus_rd(8'h08, v); check(v == 32'h02, "R6 periodic flag set", v, 32'h02);
      bus_wr(8'h08, 32'h08);
      check(irq, "R9 enabled periodic event", {31'd0, irq}, 1);
      bus_rd(8'h08, v); check(v == 32'h0A, "R8 zero write keeps flag", v, 32'h0A);
      bus_wr(8'h08, 32'h02);
      bus_rd(8'h08, v); check(v == 32'h00, "R8 one write clears flag", v, 0);
      check(!irq, "R9 irq drops after clear", {31'd0, irq}, 0);

      // R7 compare A
      bus_wr(8'h00, 32'd10);
      bus_wr(8'h04, 32'd12);
      bus_wr(8'h08, 32'h17);
      bus_wr(8'h1C, 32'd3);
      for (int k = 0; k < 2000 && !wake; k++) @(negedge clk);
      bus_wr(8'h1C, 32'd0);
      bus_rd(8'h00, v); check(v == 12, "R7 compare A count", v, 12);
      bus_rd(8'h08, v); check(v[0] == 1'b1, "R7 compare A flag bit0", v, 32'h1);
      check(wake && irq, "R9 wake on enabled alarm", {30'd0, wake, irq}, 3);
      bus_wr(8'h08, 32'h05);
      check(!wake, "R8 compare A cleared", {31'd0, wake}, 0);

      // R7 compare B
      bus_wr(8'h18, 32'd14);
      bus_wr(8'h08, 32'h53);
      bus_wr(8'h1C, 32'd3);
      for (int k = 0; k < 2000 && !wake; k++) @(negedge clk);
      bus_wr(8'h1C, 32'd0);
      bus_rd(8'h00, v); check(v == 14, "R7 compare B count", v, 14);
      bus_rd(8'h08, v); check(v[4] == 1'b1 && v[0] == 1'b0, "R7 compare B flag bit4", v, 32'h10);

      // R4 wrap sets no alarm event
      bus_wr(8'h04, 32'd5);
      bus_wr(8'h18, 32'd5);
      bus_wr(8'h00, 32'hFFFF_FFFF);
      bus_wr(8'h08, 32'h13);
      bus_wr(8'h1C, 32'd3);
      wait_status_bit(1);
      bus_wr(8'h1C, 32'd0);
      bus_rd(8'h00, v); check(v == 0, "R4 wrap to zero", v, 0);
      bus_rd(8'h08, v); check(v == 32'h02, "R4 wrap raises only periodic", v, 32'h02);

      // R10 scratch and unmapped
      bus_wr(8'h40, 32'hDEAD_BEEF);
      repeat (50) @(negedge clk);
      bus_rd(8'h40, v); check(v == 32'hDEAD_BEEF, "R10 scratch retained", v, 32'hDEAD_BEEF);
      bus_rd(8'h20, v2); check(v2 == 0, "R10 unmapped reads zero", v2, 0);
      check(rdata == v2, "R10 read data holds", rdata, v2);

      // free run under the model for a while
      bus_wr(8'h08, 32'h4C);
      bus_wr(8'h1C, 32'd3);
      repeat (600) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule